// File: doc/BRIEF.md
# Microsecond Countdown Event Timer with Timestamp

This block is a memory-mapped general-purpose timer for a system-on-chip. A prescaler divides the system clock into a one-microsecond tick. An event counter loaded by software counts down on each tick while it is enabled. When it runs out, a sticky terminal-count flag is raised, and that flag drives the interrupt line. Beside it, a free-running timestamp counter counts up on the same tick. Software uses it as a monotonic time base.

Software drives the block through a simple single-cycle register bus, with read data registered. The usual sequence has three writes. The first write clears the enable bit, which stops the counter. The second write loads a new count. The third write sets enable. A single control write that has bit 7 set acknowledges the flag. The enable bit in that same write takes effect at the same edge, so the value 0x80 both stops the counter and acknowledges the flag. The timer can also run periodically: in that mode it reloads the last programmed count each time it expires.

Top module: `countdown_timer`

## Requirements
- R1: After reset the event count, the timestamp and every control bit read as zero, and `irq` is low.
- R2: A tick occurs once every `TICK_DIV` clock cycles. While enable (control bit 0) is set, the event count drops by one on each tick. While enable is clear, the count holds its value.
- R3: A write to offset 0x0 loads the event count and also the reload value. The write is accepted whether or not the counter is running. Any value up to 0xFFFFFFFF counts down correctly.
- R4: The count expires on a tick that arrives while enable is set and the count is 1 or 0, so a programmed count N expires on the Nth tick. On expiry, control bit 7 (terminal-count flag) is set. `irq` is high exactly while that flag is set.
- R5: In one-shot mode (control bits 1 and 2 not both set), expiry leaves the count at 0 and clears enable.
- R6: In periodic mode (control bits 1 and 2 both set), expiry reloads the last value written to offset 0x0 and enable stays set.
- R7: A write to offset 0x4 sets enable, periodic and reload from data bits 0, 1 and 2. Data bit 7 = 1 clears the flag; data bit 7 = 0 leaves it unchanged. If expiry happens in the same cycle as a clearing write, the flag stays set.
- R8: Offset 0x8 returns the timestamp. It rises by one on every tick, wraps from all-ones to zero, and is not changed by writes.
- R9: Read data is registered: it updates on the edge that samples a read and otherwise holds. Offset 0x4 returns the control byte with bits 6:3 and 31:8 zero. Unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, high while the terminal-count flag is set |

## Verification
The bench aims at the edges of the countdown. A count of 1 or 0 must expire on the very next tick, and an off-by-one would raise the interrupt one tick late, or never. It sweeps a flag-clearing write across the expiry cycle; a design that let the clear win would lose an event. It also checks that a control write without bit 7 leaves a pending flag alone, and that periodic mode reloads the programmed value rather than the value zero. The timestamp is narrowed so that its wrap can be reached, and a design whose wrap, hold or write-protection is wrong shows it at once in the reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] OFS_COUNT = 4'h0;
  localparam logic [3:0] OFS_CTRL  = 4'h4;
  localparam logic [3:0] OFS_STAMP = 4'h8;

  localparam int CB_EN   = 0;
  localparam int CB_PER  = 1;
  localparam int CB_RLD  = 2;
  localparam int CB_FLAG = 7;

  typedef struct packed {
    logic flag;
    logic rld;
    logic per;
    logic en;
  } ctrl_t;

  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    logic [7:0] b;
    b = '0;
    b[CB_EN]   = c.en;
    b[CB_PER]  = c.per;
    b[CB_RLD]  = c.rld;
    b[CB_FLAG] = c.flag;
    return b;
  endfunction

  function automatic logic is_reload_mode(input ctrl_t c);
    return c.per && c.rld;
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == LAST);

      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stamp <= '0;
    else if (tick) stamp <= stamp + 1'b1;
  end

  assert_stamp_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> stamp == TS_W'($past(stamp) + 1'b1));
  assert_stamp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(stamp));
endmodule

// File: rtl/tmr_event.sv
module tmr_event
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             ctrl_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [7:0]       wctrl,
  output logic [CNT_W-1:0] cnt_q,
  output ctrl_t            ctrl_q,
  output logic             expire
);
  logic [CNT_W-1:0] reload_q;
  logic             run;
  logic             reload_mode;

  assign run         = ctrl_q.en && tick;
  assign expire      = run && (cnt_q <= CNT_W'(1));
  assign reload_mode = is_reload_mode(ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (cnt_wr) begin
      cnt_q    <= wdata;
      reload_q <= wdata;
    end else if (expire) begin
      cnt_q    <= reload_mode ? reload_q : '0;
    end else if (run) begin
      cnt_q    <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en  <= wctrl[CB_EN];
        ctrl_q.per <= wctrl[CB_PER];
        ctrl_q.rld <= wctrl[CB_RLD];
      end else if (expire && !reload_mode) begin
        ctrl_q.en  <= 1'b0;
      end
      if (expire)                         ctrl_q.flag <= 1'b1;
      else if (ctrl_wr && wctrl[CB_FLAG]) ctrl_q.flag <= 1'b0;
    end
  end

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));
  assert_flag_on_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ctrl_q.flag);
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload_mode && !ctrl_wr && !cnt_wr) |=> (!ctrl_q.en && cnt_q == '0));
  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload_mode && !cnt_wr) |=> cnt_q == $past(reload_q));
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wctrl[CB_FLAG] && !expire) |=> !ctrl_q.flag);
  assert_enable_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q.en == $past(wctrl[CB_EN]));
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import tmr_pkg::*;
#(
  parameter int TICK_DIV = 200,
  parameter int CNT_W    = 32,
  parameter int TS_W     = 32,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(OFS_STAMP);

  logic             tick;
  logic             cnt_wr, ctrl_wr, rd_req, addr_mapped;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl_q;
  logic [TS_W-1:0]  stamp;
  logic [31:0]      rd_mux;

  assign cnt_wr      = bus_sel && bus_wr && (bus_addr == A_COUNT);
  assign ctrl_wr     = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign rd_req      = bus_sel && !bus_wr;
  assign addr_mapped = (bus_addr == A_COUNT) || (bus_addr == A_CTRL) || (bus_addr == A_STAMP);

  tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  tmr_event #(.CNT_W(CNT_W)) u_event (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .wctrl(bus_wdata[7:0]),
    .cnt_q(cnt_q), .ctrl_q(ctrl_q), .expire(expire));

  tmr_stamp #(.TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stamp(stamp));

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_COUNT)      rd_mux[CNT_W-1:0] = cnt_q;
    else if (bus_addr == A_CTRL)  rd_mux[7:0]       = pack_ctrl(ctrl_q);
    else if (bus_addr == A_STAMP) rd_mux[TS_W-1:0]  = stamp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_mux;
  end

  assign irq = ctrl_q.flag;

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !addr_mapped) |=> bus_rdata == '0);
  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));
  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(expire));
  initial assert_params_R3: assert (CNT_W <= 32 && TS_W <= 32 && CNT_W >= 2);
endmodule

// File: tb/tb_countdown_timer.sv
`timescale 1ns/1ps
module tb_countdown_timer;
  localparam int DIV  = 4;
  localparam int TSW  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  countdown_timer #(.TICK_DIV(DIV), .CNT_W(32), .TS_W(TSW), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  // Behavioural reference: state as plain integers, stepped once per edge.
  longint m_cnt, m_rl, m_ts;
  bit     m_en, m_per, m_rld, m_flag;
  int     m_pc;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_rl = 0; m_ts = 0; m_pc = 0; m_rd = 0;
      m_en = 0; m_per = 0; m_rld = 0; m_flag = 0;
    end else begin
      bit t, ex, rmode;
      t = (m_pc == DIV - 1);
      ex = m_en && t && (m_cnt <= 1);
      rmode = m_per && m_rld;
      if (sel && !wr) begin
        case (addr)
          4'h0: m_rd = 32'(m_cnt);
          4'h4: m_rd = {24'd0, m_flag, 4'd0, m_rld, m_per, m_en};
          4'h8: m_rd = 32'(m_ts);
          default: m_rd = 0;
        endcase
      end
      if (sel && wr && addr == 4'h0) begin m_cnt = wdata; m_rl = wdata; end
      else if (ex) m_cnt = rmode ? m_rl : 0;
      else if (m_en && t) m_cnt = m_cnt - 1;
      if (ex) m_flag = 1;
      else if (sel && wr && addr == 4'h4 && wdata[7]) m_flag = 0;
      if (sel && wr && addr == 4'h4) begin
        m_en = wdata[0]; m_per = wdata[1]; m_rld = wdata[2];
      end else if (ex && !rmode) m_en = 0;
      if (t) m_ts = (m_ts + 1) % (longint'(1) << TSW);
      m_pc = t ? 0 : m_pc + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Continuous comparison against the reference, away from the active edge.
  always @(negedge clk) if (rst_n && !done) begin
    check("R4 irq vs flag model", {31'd0, irq}, {31'd0, m_flag});
    check("R9 rdata vs model", rdata, m_rd);
  end

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    idle(3);
    @(negedge clk) rst_n = 1;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_reg(4'h0, v); check("R1 count after reset", v, 32'd0);
    rd_reg(4'h4, v); check("R1 ctrl after reset", v, 32'd0);
    rd_reg(4'h8, v); check("R1 stamp early", v, 32'(m_ts) - 0);

    wr_reg(4'h0, 32'd15);
    rd_reg(4'h0, v); check("R3 count readback", v, 32'd15);
    rd_reg(4'hC, v); check("R9 unmapped reads zero", v, 32'd0);
    idle(20);
    rd_reg(4'h0, v); check("R2 count holds while disabled", v, 32'd15);

    // one-shot run of 15 ticks
    wr_reg(4'h4, 32'h01);
    idle(15 * DIV + 8);
    check("R4 irq after expiry", {31'd0, irq}, 32'd1);
    rd_reg(4'h4, v); check("R5 enable cleared, flag set", v, 32'h80);
    rd_reg(4'h0, v); check("R5 count parked at zero", v, 32'd0);
    wr_reg(4'h4, 32'h00);
    check("R7 write without bit7 keeps flag", {31'd0, irq}, 32'd1);
    wr_reg(4'h4, 32'h80);
    check("R7 ack drops irq", {31'd0, irq}, 32'd0);
    rd_reg(4'h4, v); check("R7 ctrl after ack", v, 32'h00);

    // periodic
    wr_reg(4'h0, 32'd5);
    wr_reg(4'h4, 32'h07);
    idle(5 * DIV * 3 + 6);
    rd_reg(4'h4, v); check("R6 periodic stays enabled", v, 32'h87);
    wr_reg(4'h4, 32'h87);
    rd_reg(4'h4, v); check("R7 ack keeps periodic running", v, 32'h07);
    idle(40);
    wr_reg(4'h4, 32'h80);
    rd_reg(4'h0, v); idle(12);
    rd_reg(4'h0, v2); check("R2 count frozen after stop", v2, v);

    // top of range
    wr_reg(4'h0, 32'hFFFF_FFFF);
    wr_reg(4'h4, 32'h01);
    idle(3 * DIV);
    wr_reg(4'h4, 32'h00);
    rd_reg(4'h0, v);
    checks++;
    if (v >= 32'hFFFF_FFFF || v < 32'hFFFF_FFF0) begin
      errors++; $display("FAIL R3 large count actual=%h expected=near FFFFFFFC", v);
    end

    // count of 1 and of 0 expire on the next tick
    wr_reg(4'h0, 32'd1); wr_reg(4'h4, 32'h01); idle(DIV + 2);
    check("R4 count one expires in one tick", {31'd0, irq}, 32'd1);
    wr_reg(4'h4, 32'h80);
    wr_reg(4'h0, 32'd0); wr_reg(4'h4, 32'h01); idle(DIV + 2);
    check("R4 count zero expires in one tick", {31'd0, irq}, 32'd1);
    wr_reg(4'h4, 32'h80);

    // clearing write swept across the expiry cycle
    for (int d = 0; d < 3 * DIV + 4; d++) begin
      wr_reg(4'h0, 32'd3);
      wr_reg(4'h4, 32'h01);
      idle(d);
      wr_reg(4'h4, 32'h81);
      idle(4 * DIV);
      wr_reg(4'h4, 32'h80);
    end

    // timestamp: writes ignored, wraps
    rd_reg(4'h8, v);
    wr_reg(4'h8, 32'h0000_0055);
    rd_reg(4'h8, v2); check("R8 stamp write ignored", v2, 32'(m_rd));
    idle(300 * DIV);
    rd_reg(4'h8, v); check("R8 stamp wraps within width", v & ~32'hFF, 32'd0);

    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule